// File: doc/BRIEF.md
# Exclusive Access Monitor

This block fronts a small shared word memory used by several requesters. It tracks one conditional-store reservation per requester so that software can build semaphores and other atomic primitives. A requester first issues a reserving load. This returns the current word and arms the requester's reservation on that word. The requester then issues a conditional store. The store reaches memory only if the reservation is still armed for the same word. Its outcome comes back as a one-bit status.

A reservation is cancelled in four ways: an explicit clear command (the hook a context switch uses), a store from a different requester to the reserved word, any conditional store by its owner, or reset. When several requesters present commands in the same cycle, a fixed-priority arbiter takes one per cycle. The response arrives one cycle after acceptance.

Top module: `excl_mon_top`

## Requirements
- R1: A reserving load (command 2) returns the addressed word and arms the issuing requester's reservation on that word.
- R2: A conditional store (command 3) while the issuer's reservation is armed on the same word writes memory and returns status 0.
- R3: A conditional store with no armed reservation leaves memory unchanged and returns status 1.
- R4: A clear command (command 4) disarms the issuer's reservation only. Reservations of other requesters are unaffected.
- R5: A write to a reserved word by another requester disarms that reservation. This covers a plain store (command 1) or a passing conditional store. A write to a different word leaves the reservation armed.
- R6: Every conditional store disarms the issuer's reservation, whether it passes or fails.
- R7: A conditional store to a word other than the reserved one fails and does not write memory.
- R8: A new reserving load replaces the requester's earlier reserved word.
- R9: Reservations are held at 32-bit word granularity, so address bits [1:0] are ignored. A plain load (command 0) never changes reservation state.
- R10: Each cycle, at most one request is accepted (ready high), and the lowest-index valid requester wins. Exactly one cycle later, rsp_valid pulses for that requester. In that cycle rsp_rdata carries the word for loads (0 otherwise) and rsp_status carries the conditional-store result (0 otherwise).
- R11: When two conditional stores to the same reserved word contend, only the first one serviced can pass.
- R12: Reset disarms all reservations and clears the memory to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle |
| req_cmd | input | 3*NREQ | Command per requester: 0 load, 1 store, 2 reserving load, 3 conditional store, 4 clear |
| req_addr | input | ADDR_W*NREQ | Byte address per requester |
| req_wdata | input | DATA_W*NREQ | Store data per requester |
| rsp_valid | output | NREQ | Response pulse for the requester accepted in the previous cycle |
| rsp_rdata | output | DATA_W | Load data |
| rsp_status | output | 1 | Conditional store result, 0 pass, 1 fail |

## Verification
The bench targets the cases that hide a stale reservation:
- A conditional store issued after the owner's clear, after a store from another requester, or after a second reserving load to another word. A design that missed any of these would report pass and overwrite the word.
- A repeated conditional store with no new reserving load. A design that kept the reservation after the first store would let it pass.
- A conditional store whose low byte-address bits differ from the reserving load's. A design that compared full byte addresses would wrongly fail it.
- Two conditional stores to the same word presented in one cycle. A design whose write did not cancel the other reservation would let both pass.
- A reset between reservation and store. A design that did not clear reservations on reset would let the store pass.

// File: rtl/excl_pkg.sv
// Shared command encoding for the exclusive access monitor.
package excl_pkg;
    typedef enum logic [2:0] {
        CMD_LOAD  = 3'd0,
        CMD_STORE = 3'd1,
        CMD_LDEX  = 3'd2,
        CMD_STEX  = 3'd3,
        CMD_CLREX = 3'd4
    } cmd_e;
endpackage

// File: rtl/excl_arb.sv
// Fixed-priority arbiter: requester 0 has highest priority.
// Assumes the caller treats gnt as the ready signal; no grant during reset.
module excl_arb #(
    parameter int NREQ = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] valid,
    output logic [NREQ-1:0] gnt
);
    logic taken;

    // Pick the lowest-index valid requester.
    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (rst_n && valid[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R10
    AST_GNT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        valid[0] |-> gnt[0]); // R10
endmodule

// File: rtl/excl_mem.sv
// Word memory with one combinational read port and one write port.
// Assumes word-indexed addressing; a synchronous reset zeroes every word.
module excl_mem #(
    parameter int WORD_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << WORD_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Read the addressed word.
    assign rdata = mem[idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(idx)] == $past(wdata)); // R2
endmodule

// File: rtl/excl_resv.sv
// Reservation table: one armed flag and one word index per requester.
// Assumes only the granted request is presented on cmd/word and that
// wr_en marks a memory write by that granted request.
module excl_resv
    import excl_pkg::*;
#(
    parameter int NREQ   = 3,
    parameter int WORD_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        gnt,
    input  cmd_e                   cmd,
    input  logic [WORD_W-1:0]      word,
    input  logic                   wr_en,
    output logic [NREQ-1:0]        armed,
    output logic [NREQ*WORD_W-1:0] resv_word
);
    for (genvar g = 0; g < NREQ; g++) begin : g_slot
        logic [WORD_W-1:0] slot_word;
        assign resv_word[g*WORD_W +: WORD_W] = slot_word;

        // Arm on own reserving load; disarm on own clear/conditional store
        // or on another requester's write to the reserved word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed[g]  <= 1'b0;
                slot_word <= '0;
            end else if (gnt[g]) begin
                if (cmd == CMD_LDEX) begin
                    armed[g]  <= 1'b1;
                    slot_word <= word;
                end else if (cmd == CMD_STEX || cmd == CMD_CLREX) begin
                    armed[g] <= 1'b0;
                end
            end else if (wr_en && slot_word == word) begin
                armed[g] <= 1'b0;
            end
        end

        AST_LDEX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[g] && cmd == CMD_LDEX) |=> (armed[g] && slot_word == $past(word))); // R1
        AST_CLREX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[g] && cmd == CMD_CLREX) |=> !armed[g]); // R4
        AST_STEX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[g] && cmd == CMD_STEX) |=> !armed[g]); // R6
        AST_SNOOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (!gnt[g] && wr_en && slot_word == word) |=> !armed[g]); // R5
        AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[g] && cmd == CMD_LOAD) |=> $stable(armed[g])); // R9
    end
endmodule

// File: rtl/excl_mon_top.sv
// Exclusive access monitor: arbitrates requesters onto a shared word
// memory and decides conditional stores from per-requester reservations.
// Assumes a request holds its inputs until its ready is seen high.
module excl_mon_top
    import excl_pkg::*;
#(
    parameter int NREQ   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req_valid,
    output logic [NREQ-1:0]        req_ready,
    input  logic [3*NREQ-1:0]      req_cmd,
    input  logic [ADDR_W*NREQ-1:0] req_addr,
    input  logic [DATA_W*NREQ-1:0] req_wdata,
    output logic [NREQ-1:0]        rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_status
);
    localparam int WORD_W = ADDR_W - 2;

    logic [NREQ-1:0]        gnt;
    logic                   any_gnt;
    logic [2:0]             sel_cmd_raw;
    cmd_e                   sel_cmd;
    logic [WORD_W-1:0]      sel_word;
    logic [DATA_W-1:0]      sel_wdata;
    logic [NREQ-1:0]        armed;
    logic [NREQ*WORD_W-1:0] resv_word;
    logic [NREQ-1:0]        slot_hit;
    logic                   stex_pass;
    logic                   mem_we;
    logic [DATA_W-1:0]      mem_rd;

    excl_arb #(.NREQ(NREQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .gnt(gnt)
    );

    assign req_ready = gnt;
    assign any_gnt   = |gnt;

    // Steer the granted requester's fields onto the shared path.
    always_comb begin
        sel_cmd_raw = '0;
        sel_word    = '0;
        sel_wdata   = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (gnt[i]) begin
                sel_cmd_raw = req_cmd[i*3 +: 3];
                sel_word    = req_addr[i*ADDR_W+2 +: WORD_W];
                sel_wdata   = req_wdata[i*DATA_W +: DATA_W];
            end
        end
    end
    assign sel_cmd = cmd_e'(sel_cmd_raw);

    // Match each reservation against the presented word.
    for (genvar g = 0; g < NREQ; g++) begin : g_hit
        assign slot_hit[g] = armed[g] && (resv_word[g*WORD_W +: WORD_W] == sel_word);
    end

    assign stex_pass = any_gnt && (sel_cmd == CMD_STEX) && |(gnt & slot_hit);
    assign mem_we    = any_gnt && ((sel_cmd == CMD_STORE) || stex_pass);

    excl_resv #(.NREQ(NREQ), .WORD_W(WORD_W)) u_resv (
        .clk(clk), .rst_n(rst_n), .gnt(gnt), .cmd(sel_cmd), .word(sel_word),
        .wr_en(mem_we), .armed(armed), .resv_word(resv_word)
    );

    excl_mem #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .idx(sel_word), .we(mem_we),
        .wdata(sel_wdata), .rdata(mem_rd)
    );

    // Register the one-cycle response for the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= '0;
            rsp_rdata  <= '0;
            rsp_status <= 1'b0;
        end else begin
            rsp_valid  <= gnt;
            rsp_rdata  <= (any_gnt && (sel_cmd == CMD_LOAD || sel_cmd == CMD_LDEX))
                          ? mem_rd : '0;
            rsp_status <= any_gnt && (sel_cmd == CMD_STEX) && !stex_pass;
        end
    end

    AST_RSP_FOLLOWS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(gnt)); // R10
    AST_UNARMED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (any_gnt && sel_cmd == CMD_STEX && !(|(gnt & armed))) |=> rsp_status); // R3
    AST_UNARMED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (any_gnt && sel_cmd == CMD_STEX && !(|(gnt & slot_hit))) |-> !mem_we); // R7
endmodule

// File: tb/tb_excl_mon_top.sv
`timescale 1ns/1ps
module tb_excl_mon_top;
    localparam int NREQ = 3, ADDR_W = 8, DATA_W = 32;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NREQ-1:0]        req_valid = '0;
    logic [NREQ-1:0]        req_ready;
    logic [3*NREQ-1:0]      req_cmd = '0;
    logic [ADDR_W*NREQ-1:0] req_addr = '0;
    logic [DATA_W*NREQ-1:0] req_wdata = '0;
    logic [NREQ-1:0]        rsp_valid;
    logic [DATA_W-1:0]      rsp_rdata;
    logic                   rsp_status;

    int checks = 0;
    int fails  = 0;

    int          q_req[$];
    logic [31:0] q_rd[$];
    logic        q_st[$];
    string       q_tag[$];

    excl_mon_top #(.NREQ(NREQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

    always #10 clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(int r, logic [2:0] c, logic [7:0] a, logic [31:0] d);
        req_valid[r]            = 1'b1;
        req_cmd[r*3 +: 3]       = c;
        req_addr[r*ADDR_W +: ADDR_W] = a;
        req_wdata[r*DATA_W +: DATA_W] = d;
    endtask

    task automatic expect_rsp(int r, logic [31:0] rd, logic st, string tag);
        q_req.push_back(r);
        q_rd.push_back(rd);
        q_st.push_back(st);
        q_tag.push_back(tag);
    endtask

    // Single request: drive at negedge, wait for acceptance, release.
    task automatic issue(int r, logic [2:0] c, logic [7:0] a, logic [31:0] d,
                         logic [31:0] rd, logic st, string tag);
        @(negedge clk);
        drive(r, c, a, d);
        expect_rsp(r, rd, st, tag);
        #1;
        while (!req_ready[r]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid[r] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && |rsp_valid) begin
            if (q_req.size() == 0) begin
                check("R10 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                automatic int          r  = q_req.pop_front();
                automatic logic [31:0] rd = q_rd.pop_front();
                automatic logic        st = q_st.pop_front();
                automatic string       tg = q_tag.pop_front();
                check({tg, " who"},    64'(rsp_valid), 64'(1 << r));
                check({tg, " rdata"},  64'(rsp_rdata), 64'(rd));
                check({tg, " status"}, 64'(rsp_status), 64'(st));
            end
        end
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R12 reset ready", 64'(req_ready), 64'd0);
        rst_n = 1'b1;

        issue(0, 3'd0, 8'h10, 0, 32'h0, 0, "R12 memory zero");
        issue(0, 3'd3, 8'h10, 32'h5, 0, 1, "R12 R3 no reservation fails");
        issue(0, 3'd0, 8'h10, 0, 32'h0, 0, "R3 memory unchanged");
        issue(0, 3'd1, 8'h10, 32'hAA, 0, 0, "R10 store");
        issue(0, 3'd2, 8'h10, 0, 32'hAA, 0, "R1 ldex returns word");
        issue(0, 3'd0, 8'h10, 0, 32'hAA, 0, "R9 plain load");
        issue(0, 3'd3, 8'h13, 32'hBB, 0, 0, "R2 R9 stex passes");
        issue(0, 3'd0, 8'h10, 0, 32'hBB, 0, "R2 memory written");
        issue(0, 3'd3, 8'h10, 32'hCC, 0, 1, "R6 second stex fails");
        issue(0, 3'd0, 8'h10, 0, 32'hBB, 0, "R6 memory unchanged");

        issue(1, 3'd2, 8'h20, 0, 0, 0, "R4 ldex r1");
        issue(0, 3'd2, 8'h20, 0, 0, 0, "R4 ldex r0");
        issue(0, 3'd4, 8'h20, 0, 0, 0, "R4 clear");
        issue(0, 3'd3, 8'h20, 32'h1, 0, 1, "R4 cleared stex fails");
        issue(1, 3'd3, 8'h20, 32'h2, 0, 0, "R4 other requester passes");
        issue(1, 3'd0, 8'h20, 0, 32'h2, 0, "R4 memory");

        issue(0, 3'd2, 8'h30, 0, 0, 0, "R5 ldex");
        issue(2, 3'd1, 8'h30, 32'h7, 0, 0, "R5 foreign store");
        issue(0, 3'd3, 8'h30, 32'h8, 0, 1, "R5 snooped stex fails");
        issue(0, 3'd0, 8'h30, 0, 32'h7, 0, "R5 memory");
        issue(0, 3'd2, 8'h30, 0, 32'h7, 0, "R5 ldex again");
        issue(2, 3'd1, 8'h34, 32'h9, 0, 0, "R5 store other word");
        issue(0, 3'd3, 8'h30, 32'h8, 0, 0, "R5 unrelated store keeps");
        issue(0, 3'd0, 8'h30, 0, 32'h8, 0, "R5 memory written");

        issue(1, 3'd2, 8'h40, 0, 0, 0, "R7 ldex");
        issue(1, 3'd3, 8'h44, 32'h3, 0, 1, "R7 wrong word fails");
        issue(1, 3'd0, 8'h44, 0, 0, 0, "R7 memory unchanged");

        issue(1, 3'd2, 8'h50, 0, 0, 0, "R8 ldex a");
        issue(1, 3'd2, 8'h54, 0, 0, 0, "R8 ldex b");
        issue(1, 3'd3, 8'h50, 32'h4, 0, 1, "R8 old word fails");
        issue(1, 3'd0, 8'h50, 0, 0, 0, "R8 memory unchanged");
        issue(1, 3'd2, 8'h50, 0, 0, 0, "R8 ldex a again");
        issue(1, 3'd2, 8'h54, 0, 0, 0, "R8 ldex b again");
        issue(1, 3'd3, 8'h54, 32'h6, 0, 0, "R8 new word passes");
        issue(1, 3'd0, 8'h54, 0, 32'h6, 0, "R8 memory");

        issue(0, 3'd2, 8'h60, 0, 0, 0, "R11 ldex r0");
        issue(1, 3'd2, 8'h60, 0, 0, 0, "R11 ldex r1");
        // Race: both conditional stores presented in the same cycle.
        @(negedge clk);
        drive(0, 3'd3, 8'h60, 32'h11);
        drive(1, 3'd3, 8'h60, 32'h22);
        expect_rsp(0, 0, 0, "R11 first passes");
        expect_rsp(1, 0, 1, "R11 second fails");
        #1;
        check("R10 priority ready", 64'(req_ready), 64'h1);
        @(posedge clk);
        @(negedge clk);
        req_valid[0] = 1'b0;
        #1;
        check("R10 next ready", 64'(req_ready), 64'h2);
        @(posedge clk);
        @(negedge clk);
        req_valid[1] = 1'b0;
        issue(0, 3'd0, 8'h60, 0, 32'h11, 0, "R11 memory");

        issue(0, 3'd2, 8'h70, 0, 0, 0, "R12 ldex before reset");
        repeat (2) @(negedge clk);
        do_reset();
        issue(0, 3'd3, 8'h70, 32'h1, 0, 1, "R12 reservation cleared");
        issue(0, 3'd0, 8'h60, 0, 32'h0, 0, "R12 memory cleared");

        repeat (4) @(negedge clk);
        check("R10 all responses seen", 64'(q_req.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule